// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global shift register that holds the outcomes of the most recent resolved branches. It also keeps a table of small saturating counters. A fetch-side lookup presents a branch address. The block forms a table index by XORing the word-aligned low address bits with the global history. In the same cycle it returns the direction held in the selected counter, together with the index it used.

When the branch resolves, the pipeline sends back the saved index and the real outcome. The block then trains that counter and shifts the outcome into the history. Because the history takes part in the index, one branch can use different counters depending on how the branches before it went.

A parameter chooses the counter width. With 2-bit counters the block uses hysteresis. With 1-bit counters each entry remembers only the last outcome. A history length of zero reduces the block to a plain table indexed by address. Entries carry no tags, so branches whose index bits match share a counter. An asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `bp_corr_predictor`

## Requirements
- R1: `lk_index` equals `lk_pc[IDX_W+1:2]` XOR the global history zero-extended to IDX_W bits, where history bit 0 is the newest outcome. It is valid in the same cycle as `lk_pc`, with no register on the lookup path.
- R2: `lk_taken` is the most significant bit of the counter at `lk_index`. For 2-bit counters, codes 00 and 01 predict not taken (0) and codes 10 and 11 predict taken (1).
- R3: With 2-bit counters, an update with `up_taken`=1 moves the counter up by one and holds it at 11. An update with `up_taken`=0 moves it down by one and holds it at 00.
- R4: With 1-bit counters (CTR_W=1), an update stores `up_taken` into the entry, so the next prediction from that entry equals the last outcome.
- R5: With HIST_W=0, `lk_index` is `lk_pc[IDX_W+1:2]` alone, whatever branches have resolved before.
- R6: On a rising edge with `up_valid`=1, the history shifts one place toward its MSB, takes `up_taken` at bit 0 and drops its oldest bit. A lookup in the same cycle still uses the history as it was before that edge. With `up_valid`=0 the history holds.
- R7: While `rst_n` is low, every counter reads weakly not taken (01, or 0 for 1-bit counters) and the history is zero. Updates take effect from the third rising edge after `rst_n` rises.
- R8: An update trains only the entry named by `up_index`. It does so whatever the current address or history. Two addresses with equal index bits share one entry, with no tag check.
- R9: When a lookup and an update select the same entry in one cycle, `lk_taken` gives the value from before the update. The trained value is visible from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | ADDR_W | Branch address presented for lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_index | output | IDX_W | Table index used by this lookup |
| up_valid | input | 1 | Resolve-side update strobe |
| up_index | input | IDX_W | Index returned by the lookup of the resolved branch |
| up_taken | input | 1 | Actual branch outcome, 1 = taken |

## Verification
The lookup results `lk_index` and `lk_taken` are combinational. The bench therefore drives `lk_pc` on a falling edge and samples one time unit later, before the next rising edge. That sampling point is also what shows the old-value rule for a same-cycle update. An update presented before a rising edge changes the counter and the history at that edge. Its effect is checked by a fresh lookup driven after the edge. After `rst_n` rises, the bench waits three rising edges before it sends any update, because the release passes through two synchronizer stages.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Two-bit counter codes, MSB is the predicted direction
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr2_e;

  // Width of the history register; a zero-length history still needs one bit of storage
  function automatic int hist_store_w(input int hist_len);
    return (hist_len == 0) ? 1 : hist_len;
  endfunction

  // Weakly-not-taken reset code for a counter of the given width
  function automatic int weak_nt_code(input int ctr_w);
    return (1 << (ctr_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/bp_fold_index.sv
module bp_fold_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4,
  parameter int HW     = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [HW-1:0]     hist,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] pc_bits;
  logic             unused_bits;

  assign pc_bits     = pc[IDX_W+1:2];
  assign unused_bits = ^{pc[ADDR_W-1:IDX_W+2], pc[1:0]};

  generate
    if (HIST_W == 0) begin : g_plain
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx         = pc_bits;
    end else begin : g_corr
      assign idx = pc_bits ^ IDX_W'(hist);
    end
  endgenerate

endmodule

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 4,
  parameter int HW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HW-1:0] hist_q
);

  generate
    if (HIST_W == 0) begin : g_none
      logic unused_in;
      assign unused_in = shift_en ^ bit_in;
      assign hist_q    = '0;
    end else begin : g_reg
      logic [HW-1:0] hist_d;
      logic [HW-1:0] hist_r;

      always_comb begin
        hist_d = hist_r;
        if (shift_en) begin
          hist_d = HW'({hist_r, bit_in});
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_r <= '0;
        end else if (shift_en) begin
          hist_r <= hist_d;
        end
      end

      assign hist_q = hist_r;
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             taken,
  output logic [CTR_W-1:0] nxt
);

  localparam logic [CTR_W-1:0] TOP = '1;
  localparam logic [CTR_W-1:0] BOT = '0;

  generate
    if (CTR_W == 1) begin : g_last
      logic unused_cur;
      assign unused_cur = cur[0];
      assign nxt        = taken;
    end else begin : g_sat
      always_comb begin
        nxt = cur;
        if (taken) begin
          if (cur != TOP) nxt = cur + 1'b1;
        end else begin
          if (cur != BOT) nxt = cur - 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [CTR_W-1:0] rd_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [CTR_W-1:0] rd_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTR_W-1:0] wr_data
);

  import bp_pkg::*;

  localparam int               DEPTH   = 1 << IDX_W;
  localparam logic [CTR_W-1:0] RST_VAL = CTR_W'(weak_nt_code(CTR_W));

  logic [CTR_W-1:0] cell_v [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      logic             we;
      logic [CTR_W-1:0] cell_d;
      logic [CTR_W-1:0] cell_q;

      assign we = wr_en && (wr_idx == IDX_W'(e));

      always_comb begin
        cell_d = cell_q;
        if (we) cell_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q <= RST_VAL;
        end else if (we) begin
          cell_q <= cell_d;
        end
      end

      assign cell_v[e] = cell_q;
    end
  endgenerate

  assign rd_a = cell_v[rd_idx_a];
  assign rd_b = cell_v[rd_idx_b];

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              up_valid,
  input  logic [IDX_W-1:0]  up_index,
  input  logic              up_taken
);

  import bp_pkg::*;

  localparam int HW = hist_store_w(HIST_W);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic [1:0] rsync_d;
  logic       rst_int_n;

  assign rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= rsync_d;
    end
  end

  assign rst_int_n = rsync_q[1];

  logic [HW-1:0]    hist_q;
  logic [CTR_W-1:0] lk_ctr;
  logic [CTR_W-1:0] up_old;
  logic [CTR_W-1:0] up_new;

  bp_fold_index #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .HW(HW)
  ) u_index (
    .pc   (lk_pc),
    .hist (hist_q),
    .idx  (lk_index)
  );

  bp_ctr_table #(
    .IDX_W(IDX_W), .CTR_W(CTR_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_idx_a (lk_index),
    .rd_a     (lk_ctr),
    .rd_idx_b (up_index),
    .rd_b     (up_old),
    .wr_en    (up_valid),
    .wr_idx   (up_index),
    .wr_data  (up_new)
  );

  bp_ctr_next #(
    .CTR_W(CTR_W)
  ) u_next (
    .cur   (up_old),
    .taken (up_taken),
    .nxt   (up_new)
  );

  bp_history #(
    .HIST_W(HIST_W), .HW(HW)
  ) u_hist (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (up_valid),
    .bit_in   (up_taken),
    .hist_q   (hist_q)
  );

  assign lk_taken = lk_ctr[CTR_W-1];

endmodule

// File: rtl/bp_corr_checker.sv
module bp_corr_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4,
  parameter int HW     = 4,
  parameter int CTR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [IDX_W-1:0]  lk_index,
  input logic              up_valid,
  input logic              up_taken,
  input logic [CTR_W-1:0]  up_old,
  input logic [CTR_W-1:0]  up_new,
  input logic [HW-1:0]     hist_q
);

  // R1 / R5: with an empty history the index is the address bits alone
  assert_clear_hist_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q == '0) |-> (lk_index == lk_pc[IDX_W+1:2]));

  // R3: training moves only toward the outcome
  assert_ctr_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (up_taken ? (up_new >= up_old) : (up_new <= up_old)));

  // R3: never more than one step per update
  assert_ctr_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> ((up_new == up_old) || (up_new == up_old + 1'b1) || (up_old == up_new + 1'b1)));

  // R6: history holds without an update
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist_q));

  generate
    if (HIST_W > 0) begin : g_shift
      // R6: outcome enters at bit 0, oldest bit leaves
      assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (hist_q == HW'({$past(hist_q), $past(up_taken)})));
    end
  endgenerate

endmodule

bind bp_corr_predictor bp_corr_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .HW(HW), .CTR_W(CTR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .lk_pc    (lk_pc),
  .lk_index (lk_index),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .up_old   (up_old),
  .up_new   (up_new),
  .hist_q   (hist_q)
);

// File: tb/sim_bp_corr_predictor.sv
module sim_bp_corr_predictor;

  localparam int CLK_P = 10;

  logic clk;
  logic rst_n;

  // u0: default 64-entry, 4-bit history, 2-bit counters
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic [5:0]  lk_index;
  logic        up_valid;
  logic [5:0]  up_index;
  logic        up_taken;

  // u1: 16-entry, no history, 1-bit counters
  logic [31:0] pc1;
  logic        tk1;
  logic [3:0]  ix1;
  logic        uv1;
  logic [3:0]  ui1;
  logic        ut1;

  int checks = 0;
  int errors = 0;

  logic [1:0] ref_ctr [64];
  logic [3:0] ref_hist;

  bp_corr_predictor u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_index(lk_index),
    .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken)
  );

  bp_corr_predictor #(.ADDR_W(32), .IDX_W(4), .HIST_W(0), .CTR_W(1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(pc1), .lk_taken(tk1), .lk_index(ix1),
    .up_valid(uv1), .up_index(ui1), .up_taken(ut1)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {outcome, address}
  localparam logic [32:0] VEC [16] = '{
    {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_0240}, {1'b0, 32'h0000_0244}, {1'b1, 32'h0000_0240}, {1'b0, 32'h0000_0244},
    {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_01fc}, {1'b1, 32'h0000_0000}, {1'b0, 32'h0000_0100}, {1'b1, 32'h0000_0100}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) ref_ctr[i] = 2'b01;
    ref_hist = '0;
  endtask

  task automatic model_update(input logic [5:0] ix, input logic t);
    if (t) begin
      if (ref_ctr[ix] != 2'b11) ref_ctr[ix] = ref_ctr[ix] + 2'd1;
    end else begin
      if (ref_ctr[ix] != 2'b00) ref_ctr[ix] = ref_ctr[ix] - 2'd1;
    end
    ref_hist = {ref_hist[2:0], t};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    model_reset();
  endtask

  // lookup, check, then resolve with the returned index
  task automatic do_branch(input logic [31:0] pc, input logic t);
    logic [5:0] ei;
    @(negedge clk);
    lk_pc = pc;
    #1;
    ei = pc[7:2] ^ {2'b00, ref_hist};
    chk(lk_index == ei, "R1 index", 32'(lk_index), 32'(ei));
    chk(lk_taken == ref_ctr[ei][1], "R2 prediction", 32'(lk_taken), 32'(ref_ctr[ei][1]));
    up_valid = 1'b1; up_index = lk_index; up_taken = t;
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    model_update(ei, t);
  endtask

  task automatic upd(input logic [5:0] ix, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_index = ix; up_taken = t;
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    model_update(ix, t);
  endtask

  task automatic probe(input logic [5:0] ix, input string req);
    @(negedge clk);
    lk_pc = {24'd0, ix ^ {2'b00, ref_hist}, 2'b00};
    #1;
    chk(lk_index == ix, req, 32'(lk_index), 32'(ix));
    chk(lk_taken == ref_ctr[ix][1], req, 32'(lk_taken), 32'(ref_ctr[ix][1]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    lk_pc = '0; up_valid = 1'b0; up_index = '0; up_taken = 1'b0;
    pc1 = '0; uv1 = 1'b0; ui1 = '0; ut1 = 1'b0;
    model_reset();
    do_reset();

    // R7: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lk_pc = 32'h0000_1000 + 32'(k * 52);
      #1;
      chk(lk_index == lk_pc[7:2], "R7 history cleared", 32'(lk_index), 32'(lk_pc[7:2]));
      chk(lk_taken == 1'b0, "R7 weakly not taken", 32'(lk_taken), 32'd0);
    end

    // R1 R2 R6: vector walk with history in the index
    for (int v = 0; v < 16; v++) begin
      do_branch(VEC[v][31:0], VEC[v][32]);
    end

    // R3: saturation at both ends
    for (int n = 0; n < 4; n++) upd(6'd40, 1'b1);
    probe(6'd40, "R3 saturate high");
    upd(6'd40, 1'b0);
    probe(6'd40, "R3 one step from top");
    upd(6'd40, 1'b0);
    probe(6'd40, "R3 drop to weak not taken");
    for (int n = 0; n < 4; n++) upd(6'd40, 1'b0);
    upd(6'd40, 1'b1);
    probe(6'd40, "R3 saturate low");
    upd(6'd40, 1'b1);
    probe(6'd40, "R3 climb from bottom");

    // R8: update touches only its index
    probe(6'd41, "R8 neighbour untouched");

    // R7: reset mid-run
    do_reset();
    @(negedge clk);
    lk_pc = 32'h0000_0100;
    #1;
    chk(lk_index == 6'h00, "R7 history after reset", 32'(lk_index), 32'h0);
    chk(lk_taken == 1'b0, "R7 counter after reset", 32'(lk_taken), 32'd0);
    probe(6'd40, "R7 trained entry reset");

    // R9 and R4 on u1: same-cycle lookup and update of one entry
    @(negedge clk);
    pc1 = 32'h0000_0014;
    uv1 = 1'b1; ui1 = 4'd5; ut1 = 1'b1;
    #1;
    chk(ix1 == 4'd5, "R5 index without history", 32'(ix1), 32'd5);
    chk(tk1 == 1'b0, "R9 old value in update cycle", 32'(tk1), 32'd0);
    @(posedge clk);
    #1;
    uv1 = 1'b0;
    chk(tk1 == 1'b1, "R9 new value next cycle", 32'(tk1), 32'd1);

    // R8: alias address shares the entry
    @(negedge clk);
    pc1 = 32'h0000_0054;
    #1;
    chk(ix1 == 4'd5, "R8 alias index", 32'(ix1), 32'd5);
    chk(tk1 == 1'b1, "R8 alias shares counter", 32'(tk1), 32'd1);

    // R4: single not-taken flips a 1-bit entry
    @(negedge clk);
    uv1 = 1'b1; ui1 = 4'd5; ut1 = 1'b0;
    @(posedge clk);
    #1;
    uv1 = 1'b0;
    chk(tk1 == 1'b0, "R4 last outcome", 32'(tk1), 32'd0);

    // R5: many updates leave u1 index unchanged
    @(negedge clk);
    pc1 = 32'h0000_0038;
    #1;
    chk(ix1 == 4'd14, "R5 no history effect", 32'(ix1), 32'd14);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule